// File: doc/BRIEF.md
# Fractional Reference Clock-Enable Bank

This block produces four clock-enable strobes from one fast source clock. Each strobe is high for single source cycles, at an average rate of the source rate multiplied by 18/F. F is a per-channel fraction from 18 to 35, so each channel runs at between roughly half the source rate and the full source rate. Downstream logic clocked by the source clock qualifies its registers with a strobe. No derived clock net is ever created.

All four channels are configured through one 32-bit control word. Each channel owns one 8-bit lane of that word, which holds a 6-bit fraction and a stop bit. The word can be replaced outright, have bits ORed in, or have bits cleared, each through its own address. Software can therefore start, stop or retune one channel without a read-modify-write that would disturb the others.

Inside each channel, a small phase accumulator adds 18 every source cycle. It emits a strobe whenever the sum reaches F, and F is then subtracted from it. A stopped channel holds its accumulator at zero, so the strobe pattern restarts in the same way every time the channel is enabled.

Top module: `frcen_bank`

## Requirements
- R1: After reset the control word reads 0x92929292. Every lane then has its stop bit (bit 7 of the lane) set and a fraction of 18. All strobes are low.
- R2: A write to address 0 replaces the whole control word. `rd_data` always shows the current word, starting the cycle after the write edge.
- R3: A write to address 1 ORs `wr_data` into the control word.
- R4: A write to address 2 clears every control bit that is 1 in `wr_data`.
- R5: A write to address 3 leaves the control word unchanged.
- R6: While bit 8n+7 of the word is 1, strobe n stays low and its accumulator is held at zero.
- R7: For channel n with stop bit 0 and an in-range fraction F (bits 8n+5..8n), counting k=1 as the first cycle in which the stop bit reads 0, strobe n is high in cycle k exactly when floor(18k/F) > floor(18(k-1)/F). This gives exactly 18 strobes in every F consecutive cycles.
- R8: A running channel with F=18 strobes every cycle.
- R9: A fraction below 18 or above 35 behaves exactly like 35.
- R10: A fraction change on a running channel takes effect in the first cycle after the write edge. The accumulator is kept below the new F, so the first F_new cycles after the change hold exactly 18 strobes.
- R11: The channels run independently. Each one follows its own lane regardless of the settings of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| addr | input | 2 | 0 replace, 1 set bits, 2 clear bits, 3 no effect |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| ce | output | 4 | Per-channel clock-enable strobes |

## Verification
The strobe outputs are compared cycle by cycle against the floor(18k/F) pattern for several channel mixes:
- **Random mixes** of in-range fractions show that each lane is decoded independently.
- **F=18** separates the every-cycle case from the fractional cases.
- **Fractions of 0 and 63** show the clamp to 35, as distinct from wrapping or stalling.
- **One stopped channel beside running ones** shows that the stop bit isolates its own lane.

Random sequences of replace, set, clear and no-effect writes are checked against a model of the word, which tells the four write kinds apart. A retune made mid-stream is checked by counting strobes, and that count exposes any accumulator left above the new fraction.

// File: rtl/frcen_pkg.sv
package frcen_pkg;
   typedef enum logic [1:0] {
      ACC_REPLACE = 2'd0,
      ACC_SETBITS = 2'd1,
      ACC_CLRBITS = 2'd2,
      ACC_NONE    = 2'd3
   } access_e;
endpackage

// File: rtl/frcen_regs.sv
module frcen_regs
   import frcen_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int FMIN   = 18,
   localparam int REG_W = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] word_q
);
   localparam logic [LANE_W-1:0] LANE_RST =
      LANE_W'((1 << (LANE_W-1)) | FMIN);
   localparam logic [REG_W-1:0] WORD_RST = {LANES{LANE_RST}};

   access_e op;
   assign op = access_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= WORD_RST;
      end else if (wr_en) begin
         case (op)
            ACC_REPLACE: word_q <= wr_data;
            ACC_SETBITS: word_q <= word_q | wr_data;
            ACC_CLRBITS: word_q <= word_q & ~wr_data;
            default:     word_q <= word_q;
         endcase
      end
   end

   // R3: bits written through the set address are all 1 afterwards, and no bit drops
   assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1) |=> ((word_q & $past(wr_data)) == $past(wr_data))
                                  && ((word_q & $past(word_q)) == $past(word_q)));
   // R4: bits written through the clear address are 0 afterwards, and no bit rises
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd2) |=> ((word_q & $past(wr_data)) == '0)
                                  && ((word_q | $past(word_q)) == $past(word_q)));
   // R5: an idle cycle or a write to the no-effect address keeps the word
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || addr == 2'd3) |=> $stable(word_q));
endmodule

// File: rtl/frcen_chan.sv
module frcen_chan #(
   parameter int FRAC_W = 6,
   parameter int NUMER  = 18,
   parameter int FMIN   = 18,
   parameter int FMAX   = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic [FRAC_W-1:0] frac,
   output logic              ce
);
   localparam logic [FRAC_W-1:0] FMIN_V = FMIN[FRAC_W-1:0];
   localparam logic [FRAC_W-1:0] FMAX_V = FMAX[FRAC_W-1:0];
   localparam logic [FRAC_W:0]   STEP   = NUMER[FRAC_W:0];

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W-1:0] eff;
   logic [FRAC_W-1:0] acc_fit;
   logic [FRAC_W:0]   sum;
   logic [FRAC_W:0]   eff_x;
   logic              wrap;

   always_comb begin
      eff     = (frac < FMIN_V || frac > FMAX_V) ? FMAX_V : frac;
      acc_fit = (acc_q >= eff) ? '0 : acc_q;
      eff_x   = {1'b0, eff};
      sum     = {1'b0, acc_fit} + STEP;
      wrap    = (sum >= eff_x);
      ce      = !stop && wrap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || stop) begin
         acc_q <= '0;
      end else if (wrap) begin
         acc_q <= FRAC_W'(sum - eff_x);
      end else begin
         acc_q <= FRAC_W'(sum);
      end
   end

   // R10: the phase left after a running cycle is below the fraction used in it
   assert_acc_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !stop |=> acc_q < $past(eff));
   // R6: a stopped channel leaves its accumulator at zero
   assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> acc_q == '0);
   // R8: the fastest setting strobes in every running cycle
   assert_full_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && eff == FMIN_V) |-> ce);
endmodule

// File: rtl/frcen_bank.sv
module frcen_bank #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int FRAC_W = 6,
   parameter int NUMER  = 18,
   parameter int FMIN   = 18,
   parameter int FMAX   = 35
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [1:0]                addr,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   output logic [LANES*LANE_W-1:0]   rd_data,
   output logic [LANES-1:0]          ce
);
   localparam int REG_W    = LANES * LANE_W;
   localparam int STOP_BIT = LANE_W - 1;

   if (LANE_W <= FRAC_W) begin : g_bad_lane
      $error("frcen_bank: stop bit must sit above the fraction field");
   end
   if (FMAX >= (1 << FRAC_W) || FMIN > FMAX) begin : g_bad_range
      $error("frcen_bank: fraction range does not fit its field");
   end
   if (NUMER > FMIN || NUMER < 1) begin : g_bad_numer
      $error("frcen_bank: numerator must be positive and no larger than FMIN");
   end

   logic [REG_W-1:0] word_q;

   frcen_regs #(
      .LANES (LANES),
      .LANE_W(LANE_W),
      .FMIN  (FMIN)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wr_data(wr_data),
      .word_q (word_q)
   );

   assign rd_data = word_q;

   for (genvar n = 0; n < LANES; n++) begin : g_chan
      frcen_chan #(
         .FRAC_W(FRAC_W),
         .NUMER (NUMER),
         .FMIN  (FMIN),
         .FMAX  (FMAX)
      ) u_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .stop (word_q[n*LANE_W + STOP_BIT]),
         .frac (word_q[n*LANE_W +: FRAC_W]),
         .ce   (ce[n])
      );
   end
endmodule

// File: tb/frcen_bank_tb.sv
`timescale 1ns/1ps
module frcen_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  ce;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] model = 32'h92929292;

   always #10 clk = ~clk;

   frcen_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .ce(ce)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int eff_f(input int f);
      return (f < 18 || f > 35) ? 35 : f;
   endfunction

   function automatic logic exp_ce(input int k, input int f);
      return ((18 * k) / f) != ((18 * (k - 1)) / f);
   endfunction

   function automatic logic [31:0] apply(input logic [31:0] w, input int a, input logic [31:0] d);
      case (a)
         0: return d;
         1: return w | d;
         2: return w & ~d;
         default: return w;
      endcase
   endfunction

   // returns at the negedge that samples the first cycle after the write edge
   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model = apply(model, a, d);
   endtask

   task automatic pattern_run(input int f0, input int f1, input int f2, input int f3,
                              input logic [3:0] stp);
      int fr[4];
      logic [31:0] w;
      fr[0] = f0; fr[1] = f1; fr[2] = f2; fr[3] = f3;
      wr(0, 32'h80808080);
      w = '0;
      for (int n = 0; n < 4; n++) w[n*8 +: 8] = {stp[n], 1'b0, 6'(fr[n])};
      wr(0, w);
      for (int k = 1; k <= 72; k++) begin
         for (int n = 0; n < 4; n++) begin
            logic e;
            string req;
            e = stp[n] ? 1'b0 : exp_ce(k, eff_f(fr[n]));
            if (stp[n]) req = "R6 stopped lane";
            else if (fr[n] < 18 || fr[n] > 35) req = "R9 clamp";
            else if (fr[n] == 18) req = "R8 full rate";
            else req = "R7/R11 pattern";
            chk(req, {31'd0, ce[n]}, {31'd0, e});
         end
         @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset word", rd_data, 32'h92929292);
      chk("R1 reset strobes", {28'd0, ce}, 32'd0);

      // register access kinds, directed then random
      wr(0, 32'h81A5C3FF); chk("R2 replace", rd_data, model);
      wr(1, 32'h00FF0000); chk("R3 set bits", rd_data, model);
      wr(2, 32'h0000C300); chk("R4 clear bits", rd_data, model);
      wr(3, 32'hFFFFFFFF); chk("R5 no-effect address", rd_data, model);
      for (int i = 0; i < 40; i++) begin
         int a;
         a = int'($urandom_range(3, 0));
         wr(a, $urandom());
         chk(a == 0 ? "R2 random" : a == 1 ? "R3 random" : a == 2 ? "R4 random" : "R5 random",
             rd_data, model);
      end

      // strobe patterns
      pattern_run(18, 35, 25, 19, 4'b0000);
      pattern_run(0, 63, 20, 17, 4'b0000);
      pattern_run(33, 18, 27, 29, 4'b0100);
      for (int r = 0; r < 3; r++)
         pattern_run(int'($urandom_range(35, 18)), int'($urandom_range(35, 18)),
                     int'($urandom_range(35, 18)), int'($urandom_range(35, 18)),
                     4'($urandom_range(15, 0)));

      // retune a running channel mid-stream
      wr(0, 32'h80808080);
      wr(0, 32'h80808014);
      repeat (13) @(negedge clk);
      wr(0, 32'h80808021);
      begin
         int cnt;
         cnt = 0;
         for (int k = 0; k < 33; k++) begin
            cnt += int'(ce[0]);
            @(negedge clk);
         end
         chk("R10 retune count", cnt, 32'd18);
      end
      wr(0, 32'h80808012);
      chk("R10 retune to 18 immediate", {31'd0, ce[0]}, 32'd1);
      wr(1, 32'h00000080);
      chk("R6 stop via set", {28'd0, ce}, 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule